// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block takes two floating-point operands in IEEE 754 binary encoding and returns one of them, the lesser or the greater, under one of three semantics. The first is a legacy min/max in which any NaN input gives a NaN. The second is a number-preferring min/max in which a quiet NaN gives way to a numeric operand. The third compares magnitudes, and it looks at the sign only when both magnitudes are equal. A 3-bit mode word, presented together with the operands, selects the semantics and the direction. Whenever the result is a NaN, it leaves the block quieted. An invalid-operation flag reports any signaling NaN input.

The exponent and fraction widths are parameters, so one source covers binary16, bfloat16, binary32 and binary64. The input side carries a valid strobe. Each accepted operation produces its result exactly one clock later, marked by an output valid strobe. There is no backpressure.

Top module: `fp_minmax_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock, and `result`/`invalid` are registered from the inputs sampled with `in_valid`. An active-low asynchronous reset clears `out_valid`, `result` and `invalid` to 0.
- R2: Mode bit 0 set selects minimum and clear selects maximum. Mode bit 1 selects number semantics. Mode bit 2 selects magnitude ordering. The codes are 0 = max, 1 = min, 2 = maxNum, 3 = minNum, 6 = maxNumMag, 7 = minNumMag.
- R3: Without magnitude mode, non-NaN operands are ordered numerically: exponent field first, then fraction field. Infinity ranks above every finite value and zero below every nonzero value, subnormals included. With differing signs the negative operand is lesser, and when both are negative the magnitude order is inverted.
- R4: -0 orders below +0. Minimum of +0 and -0 in either order is 0x80000000, and maximum is 0x00000000 (binary32).
- R5: In magnitude mode, the operand with the larger |x| is the greater. The sign decides only when the magnitudes are equal. Example: maxNumMag(-3, +2) = -3, and maxNumMag(-3, +3) = +3.
- R6: With mode bit 1 set, when exactly one operand is a quiet NaN (exponent all ones, fraction MSB set) and no operand is a signaling NaN, the result is the numeric operand and `invalid` is 0.
- R7: In all other NaN cases the result is operand a if a is a NaN, otherwise operand b. It is quieted by setting the fraction MSB, with sign and remaining payload kept.
- R8: `invalid` is 1 exactly when either operand is a signaling NaN (exponent all ones, fraction nonzero, fraction MSB clear), in every mode, and the result then follows R7.
- R9: In number mode with both operands quiet NaNs, the result follows R7 and `invalid` is 0.
- R10: While `in_valid` is low, `result` and `invalid` hold their last values.
- R11: The widths `EXP_W`/`FRAC_W` are parameters, and a binary16 instance (5/10) obeys R3–R8 with its own encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| mode | input | 3 | Selection mode word (see R2) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 1+EXP_W+FRAC_W | Selected or quieted-NaN result |
| invalid | output | 1 | Signaling NaN was present |

## Verification
The bench walks a vector table that targets signed zeros in both operand orders. A design that let the sign fall out of the tie would return the wrong zero. The table covers pairs where both operands are negative, which catch a missing inversion of the magnitude order. It also covers magnitude-mode pairs with a large negative and a small positive value, which expose a design that applies the sign too early.

NaN vectors check three things. A quiet NaN must be bypassed only in number mode. A signaling NaN must still produce a quieted NaN and raise the flag, even in number mode. When both operands are NaNs, operand a's payload must win; a design that picked b or left a signaling NaN unquieted would fail here. A binary16 instance shows that no width is fixed at 32 bits.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned MIN_BIT = 0;
  localparam int unsigned NUM_BIT = 1;
  localparam int unsigned MAG_BIT = 2;

  typedef enum logic [1:0] {
    ORD_LESS = 2'd0,
    ORD_SAME = 2'd1,
    ORD_MORE = 2'd2
  } ord_e;

  // Reverse an ordering (a<b becomes a>b).
  function automatic ord_e ord_flip(ord_e o);
    case (o)
      ORD_LESS: return ORD_MORE;
      ORD_MORE: return ORD_LESS;
      default:  return ORD_SAME;
    endcase
  endfunction

  // Fold operand signs into a magnitude ordering.
  function automatic ord_e ord_signed(ord_e mag_o, logic sa, logic sb);
    if (sa != sb) return sa ? ORD_LESS : ORD_MORE;
    if (sa)       return ord_flip(mag_o);
    return mag_o;
  endfunction
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic [W-1:0]     op,
  output logic             sign,
  output logic [MAG_W-1:0] mag,
  output logic             is_nan,
  output logic             is_snan
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = op[W-1];
  assign exp_f  = op[W-2 -: EXP_W];
  assign frac_f = op[FRAC_W-1:0];
  assign mag    = {exp_f, frac_f};

  assign is_nan  = (&exp_f) && (|frac_f);
  assign is_snan = is_nan && !frac_f[FRAC_W-1];
endmodule

// File: rtl/fmm_order.sv
module fmm_order
  import fmm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic [MAG_W-1:0]  mag_a,
  input  logic [MAG_W-1:0]  mag_b,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic [MODE_W-1:0] mode,
  output logic              pick_b
);
  // Exponent field decides first, fraction only on an exponent tie.
  function automatic ord_e mag_cmp(logic [MAG_W-1:0] x, logic [MAG_W-1:0] y);
    logic [EXP_W-1:0]  ex, ey;
    logic [FRAC_W-1:0] fx, fy;
    ex = x[MAG_W-1 -: EXP_W];
    ey = y[MAG_W-1 -: EXP_W];
    fx = x[FRAC_W-1:0];
    fy = y[FRAC_W-1:0];
    if (ex != ey) return (ex < ey) ? ORD_LESS : ORD_MORE;
    if (fx != fy) return (fx < fy) ? ORD_LESS : ORD_MORE;
    return ORD_SAME;
  endfunction

  ord_e mag_ord, full_ord, dir_ord;

  always_comb begin
    mag_ord = mag_cmp(mag_a, mag_b);
    if (!mode[MAG_BIT] || mag_ord == ORD_SAME)
      full_ord = ord_signed(mag_ord, sign_a, sign_b);
    else
      full_ord = mag_ord;
    dir_ord = mode[MIN_BIT] ? ord_flip(full_ord) : full_ord;
    pick_b  = (dir_ord == ORD_LESS);
  end
endmodule

// File: rtl/fmm_nan_path.sv
module fmm_nan_path #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         a_nan,
  output logic [W-1:0] nan_q
);
  always_comb begin
    nan_q = a_nan ? op_a : op_b;
    nan_q[FRAC_W-1] = 1'b1;
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fmm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [MODE_W-1:0] mode,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              invalid
);
  logic             sign_a, sign_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             a_nan, b_nan, a_snan, b_snan;
  logic             pick_b;
  logic [W-1:0]     nan_q;

  // Named events for the checker.
  logic             any_nan, any_snan, num_bypass;
  logic [W-1:0]     nxt_result;

  fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op(op_a), .sign(sign_a), .mag(mag_a), .is_nan(a_nan), .is_snan(a_snan));
  fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op(op_b), .sign(sign_b), .mag(mag_b), .is_nan(b_nan), .is_snan(b_snan));

  fmm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .mag_a(mag_a), .mag_b(mag_b), .sign_a(sign_a), .sign_b(sign_b),
    .mode(mode), .pick_b(pick_b));

  fmm_nan_path #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .op_a(op_a), .op_b(op_b), .a_nan(a_nan), .nan_q(nan_q));

  assign any_nan    = a_nan | b_nan;
  assign any_snan   = a_snan | b_snan;
  assign num_bypass = mode[NUM_BIT] & any_nan & ~any_snan & ~(a_nan & b_nan);

  always_comb begin
    if (num_bypass)   nxt_result = a_nan ? op_b : op_a;
    else if (any_nan) nxt_result = nan_q;
    else              nxt_result = pick_b ? op_b : op_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_result;
        invalid <= any_snan;
      end
    end
  end
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   mode,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         invalid,
  input logic         a_nan,
  input logic         b_nan,
  input logic         a_snan,
  input logic         b_snan
);
  logic res_nan;
  assign res_nan = (&result[W-2 -: EXP_W]) && (|result[FRAC_W-1:0]);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid))); // R10
  AST_FLAG_SNAN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (invalid == ($past(a_snan) || $past(b_snan)))); // R8
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_nan) |-> result[FRAC_W-1]); // R7
  AST_NUM_SKIPS_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && (a_nan ^ b_nan) && !a_snan && !b_snan) |=> !res_nan); // R6
  AST_PICKS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_nan && !b_nan) |=>
      (result == $past(op_a) || result == $past(op_b))); // R3
endmodule

bind fp_minmax_unit fmm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .mode(mode), .out_valid(out_valid), .result(result), .invalid(invalid),
  .a_nan(a_nan), .b_nan(b_nan), .a_snan(a_snan), .b_snan(b_snan));

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;
  localparam int NH = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [31:0] a32, b32, r32;
  logic [15:0] a16, b16, r16;
  logic        ov32, ov16, inv32, inv16;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_minmax_unit #(.EXP_W(8), .FRAC_W(23)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a32), .op_b(b32),
    .mode(mode), .out_valid(ov32), .result(r32), .invalid(inv32));

  fp_minmax_unit #(.EXP_W(5), .FRAC_W(10)) uut_h (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a16), .op_b(b16),
    .mode(mode), .out_valid(ov16), .result(r16), .invalid(inv16));

  // {tag, mode, a, b, expected result, expected invalid}
  localparam logic [103:0] VEC [NV] = '{
    {4'd3, 3'd0, 32'h3F800000, 32'h40000000, 32'h40000000, 1'b0}, // R3
    {4'd3, 3'd1, 32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0}, // R3
    {4'd3, 3'd0, 32'hBF800000, 32'hC0400000, 32'hBF800000, 1'b0}, // R3
    {4'd3, 3'd1, 32'hBF800000, 32'hC0400000, 32'hC0400000, 1'b0}, // R3
    {4'd3, 3'd0, 32'hC0400000, 32'h40000000, 32'h40000000, 1'b0}, // R3
    {4'd3, 3'd0, 32'h7F800000, 32'h7F7FFFFF, 32'h7F800000, 1'b0}, // R3
    {4'd3, 3'd1, 32'h00000001, 32'h00000000, 32'h00000000, 1'b0}, // R3
    {4'd3, 3'd1, 32'hFF800000, 32'hC0400000, 32'hFF800000, 1'b0}, // R3
    {4'd4, 3'd0, 32'h00000000, 32'h80000000, 32'h00000000, 1'b0}, // R4
    {4'd4, 3'd0, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0}, // R4
    {4'd4, 3'd1, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0}, // R4
    {4'd4, 3'd1, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0}, // R4
    {4'd5, 3'd6, 32'hC0400000, 32'h40000000, 32'hC0400000, 1'b0}, // R5
    {4'd5, 3'd7, 32'hC0400000, 32'h40000000, 32'h40000000, 1'b0}, // R5
    {4'd5, 3'd6, 32'hC0400000, 32'h40400000, 32'h40400000, 1'b0}, // R5
    {4'd5, 3'd7, 32'h40400000, 32'hC0400000, 32'hC0400000, 1'b0}, // R5
    {4'd6, 3'd2, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0}, // R6
    {4'd6, 3'd3, 32'hBF800000, 32'h7FC00123, 32'hBF800000, 1'b0}, // R6
    {4'd6, 3'd6, 32'h7FC00000, 32'hC0400000, 32'hC0400000, 1'b0}, // R6
    {4'd7, 3'd0, 32'h3F800000, 32'h7FC00123, 32'h7FC00123, 1'b0}, // R7
    {4'd7, 3'd1, 32'hFFC00007, 32'h3F800000, 32'hFFC00007, 1'b0}, // R7
    {4'd7, 3'd0, 32'h7FC00123, 32'hFFC00007, 32'h7FC00123, 1'b0}, // R7
    {4'd8, 3'd2, 32'h7F800001, 32'h3F800000, 32'h7FC00001, 1'b1}, // R8
    {4'd8, 3'd3, 32'h3F800000, 32'hFF800005, 32'hFFC00005, 1'b1}, // R8
    {4'd8, 3'd0, 32'h7FC00123, 32'hFF800005, 32'h7FC00123, 1'b1}, // R8
    {4'd9, 3'd2, 32'h7FC00123, 32'hFFC00007, 32'h7FC00123, 1'b0}  // R9
  };

  // binary16: {mode, a, b, expected, invalid}  (R11)
  localparam logic [51:0] HVEC [NH] = '{
    {3'd0, 16'h3C00, 16'hC000, 16'h3C00, 1'b0},
    {3'd6, 16'h3C00, 16'hC000, 16'hC000, 1'b0},
    {3'd2, 16'h7E00, 16'h3C00, 16'h3C00, 1'b0},
    {3'd0, 16'h7C01, 16'h3C00, 16'h7E01, 1'b1},
    {3'd1, 16'h0000, 16'h8000, 16'h8000, 1'b0}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = '0;
    a32 = '0; b32 = '0; a16 = '0; b16 = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {63'd0, ov32}, 64'd0);
    chk("R1 reset result", {32'd0, r32}, 64'd0);
    chk("R1 reset invalid", {63'd0, inv32}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle out_valid", {63'd0, ov32}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][99:97];
      a32  = VEC[i][96:65];
      b32  = VEC[i][64:33];
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R1 out_valid vec %0d", i), {63'd0, ov32}, 64'd1);
      chk($sformatf("R%0d/R2 result vec %0d", VEC[i][103:100], i),
          {32'd0, r32}, {32'd0, VEC[i][32:1]});
      chk($sformatf("R%0d invalid vec %0d", VEC[i][103:100], i),
          {63'd0, inv32}, {63'd0, VEC[i][0]});
    end

    // R10: idle cycle with changed inputs leaves outputs held
    in_valid = 1'b0;
    a32 = 32'h7F800001; b32 = 32'h3F800000; mode = 3'd0;
    @(negedge clk);
    chk("R1 out_valid drops", {63'd0, ov32}, 64'd0);
    chk("R10 result held", {32'd0, r32}, {32'd0, 32'h7FC00123});
    chk("R10 invalid held", {63'd0, inv32}, 64'd0);

    for (int i = 0; i < NH; i++) begin
      mode = HVEC[i][51:49];
      a16  = HVEC[i][48:33];
      b16  = HVEC[i][32:17];
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R11 out_valid half %0d", i), {63'd0, ov16}, 64'd1);
      chk($sformatf("R11 result half %0d", i), {48'd0, r16}, {48'd0, HVEC[i][16:1]});
      chk($sformatf("R11 invalid half %0d", i), {63'd0, inv16}, {63'd0, HVEC[i][0]});
    end
    in_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule